// File: doc/BRIEF.md
# Interrupt Flag and Skip Control

This block holds the interrupt state of a small 4-bit controller core. It keeps the global interrupt enable flag and the external-interrupt request flag. It also keeps three 4-bit control registers, which the core loads from and reads into its accumulator. The instruction decoder drives one strobe per relevant instruction:
- disable interrupts
- enable interrupts
- test-and-clear the request flag
- test the interrupt pin level
- register write or read, with a register select

The block answers with a skip request. The sequencer uses it to squash the following instruction.

Two control bits shape the tests. Bit 0 of the first control register (the "no-op bit") turns the flag test into an instruction with no effect. Bit 2 of the third register (the "polarity bit") selects which pin level makes the pin test skip. It also selects which pin edge raises the request flag. The pin goes through a two-flop synchronizer before either use.

Top module: `irq_skip_ctl`

## Requirements
- R1: A disable strobe clears the enable flag at the next edge. An enable strobe sets it. When both arrive together, disable wins.
- R2: With the no-op bit (register 0 bit 0) at 0, the flag test asserts skip in the same cycle if the request flag is 1 and clears the flag at the next edge. If the request flag is 0, no skip is raised.
- R3: With the no-op bit at 1, the flag test raises no skip and leaves the request flag unchanged.
- R4: The pin test asserts skip in the same cycle exactly when the synchronized pin level equals the polarity bit (register 2 bit 2). With 0 a low level skips; with 1 a high level skips.
- R5: A change on the pin reaches the level test only after two rising clock edges.
- R6: The request flag is set one edge after the synchronized pin level changes to the polarity bit's value. That is a falling edge when the polarity bit is 0 and a rising edge when it is 1. A set and a test-clear in the same cycle leave the flag at 1.
- R7: Select code 0, 1 and 2 address control registers 0, 1 and 2. A write strobe loads the selected register from the accumulator input. The read port shows the selected register in the same cycle. Select code 3 writes nothing and reads 0.
- R8: Skip is high only in a cycle in which a test strobe is present.
- R9: After a synchronous active-low reset, the enable flag, the request flag and all control registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| int_pin | input | 1 | Asynchronous external interrupt pin |
| op_di | input | 1 | Disable-interrupt strobe |
| op_ei | input | 1 | Enable-interrupt strobe |
| op_tst_ext | input | 1 | Test-and-clear request flag strobe |
| op_tst_pin | input | 1 | Pin-level test strobe |
| reg_sel | input | 2 | Control register select |
| reg_wr | input | 1 | Load selected register from accumulator |
| acc_in | input | 4 | Accumulator value to write |
| acc_out | output | 4 | Selected register value for the accumulator |
| irq_en | output | 1 | Interrupt enable flag |
| ext_req | output | 1 | External interrupt request flag |
| skip | output | 1 | Squash-next-instruction request |

## Verification
Random strobes, register writes, selects and pin toggles run against a cycle model in the bench. These show that the skip sources, the polarity bit and the no-op bit combine correctly in every mix.

A directed pin ramp counts the edges from a pin change to the level test. This separates a two-stage synchronizer from a shorter or longer one.

Directed flag sequences compare the no-op bit set with cleared, and test a flag clear that lands in the same cycle as a new edge. These show whether the no-op bit gates the clear as well as the skip, and whether the hardware set wins.

// File: rtl/irq_skip_pkg.sv
// Shared widths and register codes for the interrupt skip controller.
// Assumes a 4-bit accumulator and three control registers.
package irq_skip_pkg;
    localparam int DATA_W    = 4;
    localparam int NUM_REGS  = 3;
    localparam int SEL_W     = 2;
    localparam int REG_NOP   = 0;   // register holding the no-op bit
    localparam int REG_AUX   = 1;   // general control register
    localparam int REG_POL   = 2;   // register holding the polarity bit
    localparam int NOP_BIT   = 0;
    localparam int POL_BIT   = 2;
    typedef logic [DATA_W-1:0] nib_t;
endpackage

// File: rtl/irq_pin_sync.sv
// Synchronizes the asynchronous interrupt pin and flags an edge whose new
// level matches the requested polarity. Assumes STAGES >= 2.
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic level,
    output logic edge_hit
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level    = chain_q[STAGES-1];
    assign edge_hit = (level != prev_q) && (level == pol);
endmodule

// File: rtl/irq_ctl_regs.sv
// Bank of control registers loaded from the accumulator, with a read port.
// Select codes at or above NREGS address nothing and read as zero.
module irq_ctl_regs #(
    parameter int W     = 4,
    parameter int NREGS = 3,
    parameter int SW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    sel,
    input  logic             wr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic [NREGS*W-1:0] flat
);
    logic [W-1:0] regs_q [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        // Load register i when it is selected and written.
        always_ff @(posedge clk) begin
            if (!rst_n)                          regs_q[i] <= '0;
            else if (wr && (int'(sel) == i))     regs_q[i] <= wdata;
        end
        assign flat[i*W +: W] = regs_q[i];
    end

    // Return the selected register, or zero for an unused code.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREGS; i++)
            if (int'(sel) == i) rdata = regs_q[i];
    end
endmodule

// File: rtl/irq_flags.sv
// Holds the interrupt enable flag and the external request flag.
// Disable beats enable; a hardware set beats an instruction clear.
module irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic op_di,
    input  logic op_ei,
    input  logic req_set,
    input  logic req_clr,
    output logic en_q,
    output logic req_q
);
    // Update the enable flag from the disable and enable strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (op_di) en_q <= 1'b0;
        else if (op_ei) en_q <= 1'b1;
    end

    // Update the request flag; a set is never lost to a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       req_q <= 1'b0;
        else if (req_set) req_q <= 1'b1;
        else if (req_clr) req_q <= 1'b0;
    end
endmodule

// File: rtl/irq_skip_eval.sv
// Combinational skip decision for the flag test and the pin-level test.
// Assumes the decoder raises at most the strobes of one instruction.
module irq_skip_eval (
    input  logic tst_ext,
    input  logic tst_pin,
    input  logic nop_mode,
    input  logic pol,
    input  logic level,
    input  logic req,
    output logic skip,
    output logic req_clr
);
    logic ext_live;

    // Form the skip request and the flag clear from the active test.
    always_comb begin
        ext_live = tst_ext && !nop_mode;
        req_clr  = ext_live && req;
        skip     = (ext_live && req) || (tst_pin && (level == pol));
    end
endmodule

// File: rtl/irq_skip_ctl.sv
// Top of the interrupt flag and skip controller: ties the synchronizer,
// control registers, flags and skip logic together.
module irq_skip_ctl
    import irq_skip_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_pin,
    input  logic             op_di,
    input  logic             op_ei,
    input  logic             op_tst_ext,
    input  logic             op_tst_pin,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_wr,
    input  logic [DATA_W-1:0] acc_in,
    output logic [DATA_W-1:0] acc_out,
    output logic             irq_en,
    output logic             ext_req,
    output logic             skip
);
    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    nib_t nop_reg_q;
    nib_t pol_reg_q;
    logic nop_mode;
    logic pol_sel;
    logic sync_lvl;
    logic ext_set;
    logic ext_clr;

    assign nop_reg_q = regs_flat[REG_NOP*DATA_W +: DATA_W];
    assign pol_reg_q = regs_flat[REG_POL*DATA_W +: DATA_W];
    assign nop_mode  = nop_reg_q[NOP_BIT];
    assign pol_sel   = pol_reg_q[POL_BIT];

    irq_ctl_regs #(.W(DATA_W), .NREGS(NUM_REGS), .SW(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr),
        .wdata(acc_in), .rdata(acc_out), .flat(regs_flat)
    );

    irq_pin_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(int_pin), .pol(pol_sel),
        .level(sync_lvl), .edge_hit(ext_set)
    );

    irq_skip_eval u_eval (
        .tst_ext(op_tst_ext), .tst_pin(op_tst_pin), .nop_mode(nop_mode),
        .pol(pol_sel), .level(sync_lvl), .req(ext_req),
        .skip(skip), .req_clr(ext_clr)
    );

    irq_flags u_flags (
        .clk(clk), .rst_n(rst_n), .op_di(op_di), .op_ei(op_ei),
        .req_set(ext_set), .req_clr(ext_clr),
        .en_q(irq_en), .req_q(ext_req)
    );
endmodule

// File: rtl/irq_skip_ctl_chk.sv
// Property checker for irq_skip_ctl, attached by bind.
module irq_skip_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_di,
    input logic       op_ei,
    input logic       op_tst_ext,
    input logic       op_tst_pin,
    input logic [1:0] reg_sel,
    input logic [3:0] acc_out,
    input logic       irq_en,
    input logic       ext_req,
    input logic       skip,
    input logic       nop_mode,
    input logic       pol_sel,
    input logic       sync_lvl,
    input logic       ext_set
);
    p_di_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_di |=> !irq_en);
    p_ei_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ei && !op_di) |=> irq_en);
    p_ext_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_tst_ext && !nop_mode && ext_req && !ext_set) |=> !ext_req);
    p_ext_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_tst_ext && !nop_mode && !op_tst_pin) |-> (skip == ext_req));
    p_ext_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_tst_ext && nop_mode && !op_tst_pin) |-> !skip);
    p_ext_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_tst_ext && nop_mode && !ext_set) |=> (ext_req == $past(ext_req)));
    p_pin_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_tst_pin && !op_tst_ext) |-> (skip == (sync_lvl == pol_sel)));
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_set |=> ext_req);
    p_sel_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> (acc_out == 4'd0));
    p_skip_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (op_tst_ext || op_tst_pin));
endmodule

bind irq_skip_ctl irq_skip_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_di(op_di), .op_ei(op_ei),
    .op_tst_ext(op_tst_ext), .op_tst_pin(op_tst_pin), .reg_sel(reg_sel),
    .acc_out(acc_out), .irq_en(irq_en), .ext_req(ext_req), .skip(skip),
    .nop_mode(nop_mode), .pol_sel(pol_sel), .sync_lvl(sync_lvl),
    .ext_set(ext_set)
);

// File: tb/irq_skip_ctl_bench.sv
`timescale 1ns/1ps
module irq_skip_ctl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic int_pin = 1'b0;
    logic op_di = 1'b0, op_ei = 1'b0, op_tst_ext = 1'b0, op_tst_pin = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic reg_wr = 1'b0;
    logic [3:0] acc_in = 4'd0;
    logic [3:0] acc_out;
    logic irq_en, ext_req, skip;

    int total = 0;
    int bad = 0;

    // Bench model state.
    logic m_s1, m_s2, m_prev, m_en, m_req;
    logic [3:0] m_r [3];

    irq_skip_ctl u_irq_skip_ctl (
        .clk(clk), .rst_n(rst_n), .int_pin(int_pin), .op_di(op_di),
        .op_ei(op_ei), .op_tst_ext(op_tst_ext), .op_tst_pin(op_tst_pin),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .acc_in(acc_in),
        .acc_out(acc_out), .irq_en(irq_en), .ext_req(ext_req), .skip(skip)
    );

    always #2.5 clk = ~clk;

    function automatic logic exp_skip();
        logic s;
        s = (op_tst_ext && !m_r[0][0] && m_req) ||
            (op_tst_pin && (m_s2 == m_r[2][2]));
        return s;
    endfunction

    function automatic logic [3:0] exp_acc();
        return (reg_sel == 2'd3) ? 4'd0 : m_r[reg_sel];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare outputs, advance one edge, update the model.
    task automatic tick();
        logic set, clr;
        #1;
        check(op_tst_ext ? "R2" : (op_tst_pin ? "R4" : "R8"), skip, exp_skip());
        check("R7", acc_out, exp_acc());
        check("R1", irq_en, m_en);
        check("R6", ext_req, m_req);
        @(posedge clk);
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_en = 0; m_req = 0;
            for (int i = 0; i < 3; i++) m_r[i] = 4'd0;
        end else begin
            set = (m_s2 != m_prev) && (m_s2 == m_r[2][2]);
            clr = op_tst_ext && !m_r[0][0] && m_req;
            if (op_di) m_en = 0; else if (op_ei) m_en = 1;
            if (set) m_req = 1; else if (clr) m_req = 0;
            if (reg_wr && reg_sel != 2'd3) m_r[reg_sel] = acc_in;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = int_pin;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        op_di = 0; op_ei = 0; op_tst_ext = 0; op_tst_pin = 0; reg_wr = 0;
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [3:0] v);
        idle(); reg_sel = s; reg_wr = 1; acc_in = v; tick(); reg_wr = 0;
    endtask

    initial begin
        #100000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        tick(); tick();
        rst_n = 1;
        // R9: reset state
        check("R9", irq_en, 0); check("R9", ext_req, 0);
        for (int i = 0; i < 4; i++) begin
            reg_sel = 2'(i); #0.1; check("R9", acc_out, 0);
        end
        // R1: enable, then both together
        op_ei = 1; tick(); idle(); check("R1", irq_en, 1);
        op_di = 1; op_ei = 1; tick(); idle(); check("R1", irq_en, 0);
        // R7: select 3 write has no effect on real registers
        wr_reg(2'd0, 4'h5); wr_reg(2'd1, 4'hA); wr_reg(2'd3, 4'hF);
        reg_sel = 2'd0; #0.1; check("R7", acc_out, 5);
        reg_sel = 2'd1; #0.1; check("R7", acc_out, 10);
        reg_sel = 2'd2; #0.1; check("R7", acc_out, 0);
        reg_sel = 2'd3; #0.1; check("R7", acc_out, 0);
        // R5: polarity high, pin ramp
        wr_reg(2'd2, 4'h4);
        int_pin = 0; repeat (3) tick();
        int_pin = 1; op_tst_pin = 1; #0.1; check("R5", skip, 0); tick();
        #0.1; check("R5", skip, 0); tick();
        #0.1; check("R5", skip, 1); tick(); idle();
        // R3: no-op bit set, polarity low, falling edge sets flag
        wr_reg(2'd2, 4'h0); wr_reg(2'd0, 4'h1);
        int_pin = 1; repeat (4) tick();
        int_pin = 0; repeat (4) tick();
        check("R6", ext_req, 1);
        op_tst_ext = 1; #0.1; check("R3", skip, 0); tick(); idle();
        check("R3", ext_req, 1);
        // R6: set and clear in the same cycle
        wr_reg(2'd0, 4'h0);
        int_pin = 1; repeat (3) tick();
        int_pin = 0; tick(); tick();
        op_tst_ext = 1; #0.1; check("R2", skip, 1); tick(); idle();
        check("R6", ext_req, 1);
        op_tst_ext = 1; #0.1; check("R2", skip, 1); tick(); idle();
        check("R2", ext_req, 0);
        op_tst_ext = 1; #0.1; check("R2", skip, 0); tick(); idle();
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            idle();
            case ($urandom % 8)
                0: op_di = 1;
                1: op_ei = 1;
                2, 3: op_tst_ext = 1;
                4, 5: op_tst_pin = 1;
                6: reg_wr = 1;
                default: ;
            endcase
            reg_sel = 2'($urandom % 4);
            acc_in = 4'($urandom);
            if ($urandom % 4 == 0) int_pin = ~int_pin;
            tick();
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule